// File: doc/BRIEF.md
# Processor memory request encoder

This block sits on the processor side of a synchronous 64-bit memory bus and turns the pending instruction-fetch or load/store request into the bus request lines. In the same cycle, with no register on the way, it drives the 32-bit virtual address, a 6-bit address space identifier, a 2-bit size code, a 2-bit type code and, for stores, the write data. It also raises a nullify output that tells the external cache to drop the access it has just captured.

When both requests are pending, the load/store request owns the bus. A load/store that is not naturally aligned raises an alignment-error output and is nullified, so no bus access starts. When the bus controller asserts bus-not-available, the block releases the low address bits, the data lines and the low type bit. The block models the three-state drivers with one output-enable per line group. The high address bits and the high type bit stay driven. All request, flag and enable pins are plain level signals that are valid in every cycle. There is no valid/ready handshake, because the block holds no storage and cannot apply back-pressure. The clock and reset are used only by the embedded checks.

Top module: `mr_bus_drv`

## Requirements
- R1: When a fetch is selected, the space identifier is binary 00100s, where s is the supervisor flag.
- R2: When a load/store without the alternate flag is selected, the space identifier is binary 00101s.
- R3: An alternate-space load/store drives the space identifier from its 6-bit immediate input.
- R4: The size code is 11 for a fetch and for a doubleword load/store. For a load/store it equals the request's size field (00 byte, 01 halfword, 10 word, 11 doubleword).
- R5: Type bit 1 is the lock flag of a load/store and 0 for a fetch. Type bit 0 is 1 for a read, including every fetch, and 0 for a store.
- R6: When a load/store is pending, it is selected over a fetch: the load/store address drives the address lines. Otherwise the fetch address drives them.
- R7: For a selected fetch, nullify is 1 on an instruction-cache hit, and also on a miss when the fast branch was not taken.
- R8: Nullify is 1 whenever the exception-pending input is 1.
- R9: Nullify is 1 when neither a fetch nor a load/store is pending.
- R10: A selected load/store raises the alignment error and nullify if its address is not a multiple of its size (2, 4 or 8 bytes). Byte accesses never raise the error. The error is 0 when no load/store is selected.
- R11: While bus-not-available is 1, the enables for address bits 17:0, the data lines and type bit 0 are 0. The enable for address bits 31:18 is always 1.
- R12: The data enable is 1 only for a selected store while the bus is available. The data lines then carry the store data; otherwise they carry zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Active-low reset for the embedded checks |
| fetch_req_i | input | 1 | Instruction fetch pending |
| fetch_addr_i | input | 32 | Fetch virtual address |
| ls_req_i | input | 1 | Load/store pending |
| ls_addr_i | input | 32 | Load/store virtual address |
| ls_size_i | input | 2 | Load/store size: 00 byte, 01 half, 10 word, 11 double |
| ls_write_i | input | 1 | 1 for store, 0 for load |
| ls_lock_i | input | 1 | Atomic access |
| ls_alt_i | input | 1 | Alternate-space access |
| ls_asi_imm_i | input | 6 | Immediate space identifier for alternate access |
| ls_wdata_i | input | 64 | Store data |
| super_i | input | 1 | Supervisor privilege |
| ic_hit_i | input | 1 | Instruction cache hit |
| fbr_taken_i | input | 1 | Fast branch taken on the current miss |
| exc_pend_i | input | 1 | Exception pending |
| bna_i | input | 1 | Bus not available |
| addr_o | output | 32 | Address lines |
| addr_hi_oe_o | output | 1 | Enable for address bits 31:18 |
| addr_lo_oe_o | output | 1 | Enable for address bits 17:0 |
| asi_o | output | 6 | Space identifier |
| size_o | output | 2 | Size code |
| type_o | output | 2 | Type code: bit 1 locked, bit 0 read |
| type0_oe_o | output | 1 | Enable for type bit 0 |
| data_o | output | 64 | Store data lines |
| data_oe_o | output | 1 | Enable for data lines |
| nullify_o | output | 1 | Cancel the current external access |
| align_err_o | output | 1 | Misaligned load/store |

## Verification
The bench builds the block with its default parameters: 32 address bits, 64 data bits and a high address group that starts at bit 18. With these values it reaches every space-identifier pattern and every size code. It also reaches every alignment boundary up to 8 bytes and the exact split point between the address lines that stay driven and those that are released. Random requests are mixed with aligned and misaligned addresses and with all flag combinations, so that the two-request priority and every nullify condition are exercised together with bus-not-available.

// File: rtl/mr_pkg.sv
package mr_pkg;
  localparam int MR_ASI_W = 6;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } mr_size_e;

  localparam logic [3:0] ASI_STEM = 4'b0010;
endpackage

// File: rtl/mr_align_chk.sv
module mr_align_chk
  import mr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              active_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  mr_size_e          size_i,
  output logic              misal_o
);
  logic [2:0] low_mask;

  always_comb begin
    case (size_i)
      SZ_HALF:  low_mask = 3'b001;
      SZ_WORD:  low_mask = 3'b011;
      SZ_DWORD: low_mask = 3'b111;
      default:  low_mask = 3'b000;
    endcase
    misal_o = active_i && ((addr_i[2:0] & low_mask) != 3'b000);
  end
endmodule

// File: rtl/mr_code_enc.sv
module mr_code_enc
  import mr_pkg::*;
(
  input  logic                sel_ls_i,
  input  logic                super_i,
  input  logic                alt_i,
  input  logic [MR_ASI_W-1:0] asi_imm_i,
  input  mr_size_e            size_i,
  input  logic                lock_i,
  input  logic                write_i,
  output logic [MR_ASI_W-1:0] asi_o,
  output logic [1:0]          size_o,
  output logic [1:0]          type_o
);
  always_comb begin
    if (sel_ls_i) begin
      asi_o  = alt_i ? asi_imm_i : {ASI_STEM, 1'b1, super_i};
      size_o = size_i;
      type_o = {lock_i, ~write_i};
    end else begin
      asi_o  = {ASI_STEM, 1'b0, super_i};
      size_o = SZ_DWORD;
      type_o = 2'b01;
    end
  end
endmodule

// File: rtl/mr_null_gen.sv
module mr_null_gen (
  input  logic fetch_req_i,
  input  logic ls_req_i,
  input  logic ic_hit_i,
  input  logic fbr_taken_i,
  input  logic exc_pend_i,
  input  logic misal_i,
  output logic sel_ls_o,
  output logic nullify_o
);
  logic fetch_cancel;
  logic idle;

  always_comb begin
    sel_ls_o     = ls_req_i;
    idle         = !fetch_req_i && !ls_req_i;
    fetch_cancel = !ls_req_i && fetch_req_i && (ic_hit_i || !fbr_taken_i);
    nullify_o    = idle || exc_pend_i || fetch_cancel || misal_i;
  end
endmodule

// File: rtl/mr_bus_drv.sv
module mr_bus_drv
  import mr_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int HI_BASE = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fetch_req_i,
  input  logic [ADDR_W-1:0]   fetch_addr_i,
  input  logic                ls_req_i,
  input  logic [ADDR_W-1:0]   ls_addr_i,
  input  logic [1:0]          ls_size_i,
  input  logic                ls_write_i,
  input  logic                ls_lock_i,
  input  logic                ls_alt_i,
  input  logic [MR_ASI_W-1:0] ls_asi_imm_i,
  input  logic [DATA_W-1:0]   ls_wdata_i,
  input  logic                super_i,
  input  logic                ic_hit_i,
  input  logic                fbr_taken_i,
  input  logic                exc_pend_i,
  input  logic                bna_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                addr_hi_oe_o,
  output logic                addr_lo_oe_o,
  output logic [MR_ASI_W-1:0] asi_o,
  output logic [1:0]          size_o,
  output logic [1:0]          type_o,
  output logic                type0_oe_o,
  output logic [DATA_W-1:0]   data_o,
  output logic                data_oe_o,
  output logic                nullify_o,
  output logic                align_err_o
);
  localparam int LO_W = HI_BASE;

  logic sel_ls;
  logic misal;

  mr_align_chk #(.ADDR_W(ADDR_W)) u_align (
    .active_i (ls_req_i),
    .addr_i   (ls_addr_i),
    .size_i   (mr_size_e'(ls_size_i)),
    .misal_o  (misal)
  );

  mr_null_gen u_null (
    .fetch_req_i (fetch_req_i),
    .ls_req_i    (ls_req_i),
    .ic_hit_i    (ic_hit_i),
    .fbr_taken_i (fbr_taken_i),
    .exc_pend_i  (exc_pend_i),
    .misal_i     (misal),
    .sel_ls_o    (sel_ls),
    .nullify_o   (nullify_o)
  );

  mr_code_enc u_code (
    .sel_ls_i  (sel_ls),
    .super_i   (super_i),
    .alt_i     (ls_alt_i),
    .asi_imm_i (ls_asi_imm_i),
    .size_i    (mr_size_e'(ls_size_i)),
    .lock_i    (ls_lock_i),
    .write_i   (ls_write_i),
    .asi_o     (asi_o),
    .size_o    (size_o),
    .type_o    (type_o)
  );

  always_comb begin
    addr_o       = sel_ls ? ls_addr_i : fetch_addr_i;
    addr_hi_oe_o = 1'b1;
    addr_lo_oe_o = !bna_i;
    type0_oe_o   = !bna_i;
    data_oe_o    = !bna_i && sel_ls && ls_write_i;
    data_o       = data_oe_o ? ls_wdata_i : '0;
    align_err_o  = misal;
  end

  // Checks next to the logic they guard
  assert_bna_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bna_i |-> (!addr_lo_oe_o && !data_oe_o && !type0_oe_o && addr_hi_oe_o));

  assert_exc_null_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pend_i |-> nullify_o);

  assert_idle_null_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_req_i && !ls_req_i) |-> (nullify_o && !align_err_o));

  assert_align_null_R10: assert property (@(posedge clk) disable iff (!rst_n)
    align_err_o |-> (nullify_o && ls_req_i));

  assert_fetch_codes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req_i && !ls_req_i) |-> (size_o == 2'b11 && type_o == 2'b01));

  assert_ls_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ls_req_i |-> (addr_o == ls_addr_i));

  assert_store_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> (ls_req_i && ls_write_i && data_o == ls_wdata_i));

  assert_fetch_asi_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req_i && !ls_req_i) |-> (asi_o[5:1] == 5'b00100 && asi_o[0] == super_i));

  assert_low_width_sane: assert property (@(posedge clk) disable iff (!rst_n)
    addr_lo_oe_o |-> (addr_o[LO_W-1:0] == (ls_req_i ? ls_addr_i[LO_W-1:0] : fetch_addr_i[LO_W-1:0])));
endmodule

// File: tb/mr_bus_drv_tb_top.sv
module mr_bus_drv_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic        fetch_req, ls_req, ls_write, ls_lock, ls_alt, super_f;
  logic        ic_hit, fbr_taken, exc_pend, bna;
  logic [31:0] fetch_addr, ls_addr;
  logic [1:0]  ls_size;
  logic [5:0]  asi_imm;
  logic [63:0] wdata;
  logic [31:0] addr;
  logic        hi_oe, lo_oe, t0_oe, d_oe, nullify, aerr;
  logic [5:0]  asi;
  logic [1:0]  size, typ;
  logic [63:0] data;

  int checks = 0;
  int errors = 0;

  mr_bus_drv dut_i (
    .clk(clk), .rst_n(rst_n),
    .fetch_req_i(fetch_req), .fetch_addr_i(fetch_addr),
    .ls_req_i(ls_req), .ls_addr_i(ls_addr), .ls_size_i(ls_size),
    .ls_write_i(ls_write), .ls_lock_i(ls_lock), .ls_alt_i(ls_alt),
    .ls_asi_imm_i(asi_imm), .ls_wdata_i(wdata), .super_i(super_f),
    .ic_hit_i(ic_hit), .fbr_taken_i(fbr_taken), .exc_pend_i(exc_pend),
    .bna_i(bna), .addr_o(addr), .addr_hi_oe_o(hi_oe), .addr_lo_oe_o(lo_oe),
    .asi_o(asi), .size_o(size), .type_o(typ), .type0_oe_o(t0_oe),
    .data_o(data), .data_oe_o(d_oe), .nullify_o(nullify), .align_err_o(aerr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Behavioural reference, evaluated from the requirement text
  task automatic compare();
    int bytes;
    bit ls_sel, bad, e_null, e_doe;
    logic [5:0] e_asi;
    ls_sel = ls_req;
    bytes = 1 << ls_size;
    bad = ls_sel && (ls_addr % bytes != 0);
    if (!ls_sel) e_asi = 6'd8 + {5'd0, super_f};
    else if (ls_alt) e_asi = asi_imm;
    else e_asi = 6'd10 + {5'd0, super_f};
    chk(ls_sel ? "R2/R3 asi" : "R1 asi", {58'd0, asi}, {58'd0, e_asi});
    chk("R4 size", {62'd0, size}, ls_sel ? {62'd0, ls_size} : 64'd3);
    chk("R5 type", {62'd0, typ}, ls_sel ? {62'd0, ls_lock, !ls_write} : 64'd1);
    chk("R6 addr", {32'd0, addr}, {32'd0, ls_sel ? ls_addr : fetch_addr});
    e_null = 0;
    if (!fetch_req && !ls_req) e_null = 1;
    if (exc_pend) e_null = 1;
    if (!ls_sel && fetch_req && (ic_hit || !fbr_taken)) e_null = 1;
    if (bad) e_null = 1;
    chk("R7/R8/R9 nullify", {63'd0, nullify}, {63'd0, e_null});
    chk("R10 align", {63'd0, aerr}, {63'd0, bad});
    chk("R11 enables", {61'd0, hi_oe, lo_oe, t0_oe}, {61'd0, 1'b1, !bna, !bna});
    e_doe = !bna && ls_sel && ls_write;
    chk("R12 data_oe", {63'd0, d_oe}, {63'd0, e_doe});
    chk("R12 data", data, e_doe ? wdata : 64'd0);
  endtask

  task automatic idle_inputs();
    fetch_req = 0; ls_req = 0; ls_write = 0; ls_lock = 0; ls_alt = 0;
    super_f = 0; ic_hit = 0; fbr_taken = 0; exc_pend = 0; bna = 0;
    fetch_addr = 0; ls_addr = 0; ls_size = 0; asi_imm = 0; wdata = 0;
  endtask

  task automatic step();
    @(negedge clk);
    #3;
    compare();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    #3;
    chk("R9 reset idle nullify", {63'd0, nullify}, 64'd1);
    rst_n = 1;
    // R7: fetch hit, then miss with fast branch taken / not taken
    @(negedge clk); fetch_req = 1; fetch_addr = 32'h0000_1000; ic_hit = 1; fbr_taken = 1; step();
    @(negedge clk); ic_hit = 0; step();
    chk("R7 miss taken no nullify", {63'd0, nullify}, 64'd0);
    @(negedge clk); fbr_taken = 0; step();
    // R1 supervisor fetch
    @(negedge clk); super_f = 1; fbr_taken = 1; step();
    chk("R1 supervisor fetch asi", {58'd0, asi}, 64'h9);
    // R10 boundaries for every size
    for (int s = 0; s < 4; s++) begin
      for (int off = 0; off < 8; off++) begin
        @(negedge clk); ls_req = 1; ls_size = s[1:0]; ls_addr = 32'h0004_0000 + off; step();
      end
    end
    // R3 alternate, R12 store, R11 bus released
    @(negedge clk); ls_alt = 1; asi_imm = 6'h2b; ls_size = 2'b10; ls_addr = 32'h8000_0004;
    ls_write = 1; wdata = 64'hdead_beef_0123_4567; step();
    chk("R3 alt asi", {58'd0, asi}, 64'h2b);
    @(negedge clk); bna = 1; step();
    chk("R11 data released", {63'd0, d_oe}, 64'd0);
    @(negedge clk); bna = 0; exc_pend = 1; step();
    chk("R8 exception nullify", {63'd0, nullify}, 64'd1);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      fetch_req = $urandom_range(0, 1); ls_req = $urandom_range(0, 3) == 0;
      ls_write = $urandom_range(0, 1); ls_lock = $urandom_range(0, 1);
      ls_alt = $urandom_range(0, 1); super_f = $urandom_range(0, 1);
      ic_hit = $urandom_range(0, 1); fbr_taken = $urandom_range(0, 1);
      exc_pend = $urandom_range(0, 7) == 0; bna = $urandom_range(0, 3) == 0;
      fetch_addr = $urandom; ls_addr = $urandom; ls_size = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 1) ls_addr[2:0] = 3'b000;
      asi_imm = 6'($urandom); wdata = {$urandom, $urandom};
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule